// File: doc/BRIEF.md
# Strided Banked Memory-to-Memory DMA Engine

This block is a DMA bus master for a CPU memory map with two kinds of RAM. Plain base RAM sits below a fixed window base, and an 8 KB window above it shows one bank of a larger store at a time. Software loads a pair of cursors, source and destination. Each cursor has a 16-bit address, a signed step and a bank number. Software also loads a byte count, then writes the control register to launch the transfer. Each byte is moved with a read bus cycle followed by a write bus cycle. The engine holds the bus request for the whole transfer and has no storage of its own beyond a one-byte holding register.

A cursor that starts inside the window wraps to the other end of the window when it steps past either edge. Its bank number follows the direction of the step. A base-RAM cursor that would step below address 0, or forward into the window region or above, stops the transfer early. The count left over shows how many bytes were not moved. The launch word carries one restore flag per changing field: source address, destination address, source bank, destination bank and count. A set flag puts that field back to its launch value at the end. A clear flag leaves the final value, so a follow-on transfer can continue where the last one stopped.

Top module: `strided_bank_dma`

## Requirements
- R1: After synchronous reset, every register reads 0, the status word reads 0 and `mem_req` is low.
- R2: Register select codes are 0 source address, 1 destination address, 2 source step, 3 destination step, 4 source bank, 5 destination bank, 6 count and 7 control. A write to select 0 to 6 while idle is read back unchanged. Bank values are zero-extended to 16 bits on read.
- R3: Every byte takes exactly two bus clocks. The first is a read (`mem_we`=0) at the source address and bank. The second is a write (`mem_we`=1) at the destination address and bank, carrying the byte just read. `mem_req` stays high from the first read to the last write, so a transfer of N bytes costs 2N requesting clocks.
- R4: Steps are two's-complement. A step of 0 keeps that cursor's address and bank fixed, so every byte goes to the same location.
- R5: For a cursor inside the window [0xA000, 0xC000), a step that reaches 0xC000 or beyond subtracts 0x2000 and increments the bank. A step that falls below 0xA000 adds 0x2000 and decrements the bank. Banks wrap modulo 256.
- R6: If, after a byte that is not the last, a cursor outside the window would step below 0, or past 0xFFFF, or from below 0xA000 to 0xA000 or above, the transfer stops. The count then holds the bytes not yet moved, and both cursors keep the address and bank of the last byte moved. A cursor step after the final byte never stops the transfer.
- R7: With all restore flags clear, a completed transfer leaves the count at 0. Each address is left one step past its last byte (modulo 2^16, with window wrap), and each bank is where the next byte would be.
- R8: Control write bits are [0] source address, [1] destination address, [2] source bank, [3] destination bank and [4] count. A set bit restores that field's launch value when the transfer ends, whether it completes or stops early.
- R9: A control write with a count of 0 makes no bus cycles and leaves all registers unchanged.
- R10: Register writes of any select, including the control register, are ignored while a transfer runs.
- R11: Status (select 7 read) bit 0 is 1 exactly while a transfer runs. Bit 1 is 1 when the last launched transfer stopped early under R6, and is cleared by the next accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational from cfg_sel) |
| mem_req | output | 1 | Bus ownership request, high for the whole transfer |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_addr | output | 16 | Bus address |
| mem_bank | output | 8 | Bank number qualifying window addresses |
| mem_wdata | output | 8 | Data for write cycles |
| mem_rdata | input | 8 | Data returned on read cycles |

## Verification
The hardest case to reach is an early stop: a cursor has to come within a few steps of address 0 or of the window base with bytes still to move. Stimulus of uniform random addresses almost never reaches it. Directed runs therefore place cursors a few bytes from those edges with negative and positive steps. They also cover the case where the edge is crossed only by the step after the final byte, which must not count as a stop. A launch with restore flags set after an early stop shows that restores apply on that path too. The random runs mix window and base cursors, small signed steps and random banks against a bench model that moves the same bytes in a mirror memory.

// File: rtl/sbdma_pkg.sv
`timescale 1ns/1ps
package sbdma_pkg;
    localparam int ADDR_W = 16;
    localparam int BANK_W = 8;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int REG_W  = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xfer_state_e;

    typedef enum logic [2:0] {
        RA_SRC_PTR  = 3'd0,
        RA_DST_PTR  = 3'd1,
        RA_SRC_STEP = 3'd2,
        RA_DST_STEP = 3'd3,
        RA_SRC_BANK = 3'd4,
        RA_DST_BANK = 3'd5,
        RA_COUNT    = 3'd6,
        RA_CTRL     = 3'd7
    } reg_sel_e;

    // restore flag positions in the control write word
    localparam int FL_PTR_BASE  = 0;  // +side
    localparam int FL_BANK_BASE = 2;  // +side
    localparam int FL_COUNT     = 4;
    localparam int FLAG_W       = 5;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
    } cursor_t;

    function automatic logic [REG_W-1:0] widen_bank(input logic [BANK_W-1:0] b);
        return REG_W'(b);
    endfunction
endpackage

// File: rtl/sbdma_ptr_step.sv
`timescale 1ns/1ps
module sbdma_ptr_step #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter logic [ADDR_W-1:0] WIN_LO   = 16'hA000,
    parameter logic [ADDR_W-1:0] WIN_SPAN = 16'h2000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              esc_o
);
    localparam int SW = ADDR_W + 2;
    localparam logic signed [SW-1:0] LO_S   = $signed({2'b00, WIN_LO});
    localparam logic signed [SW-1:0] SPAN_S = $signed({2'b00, WIN_SPAN});
    localparam logic signed [SW-1:0] HI_S   = LO_S + SPAN_S;
    localparam logic signed [SW-1:0] TOP_S  = $signed({2'b00, {ADDR_W{1'b1}}});

    logic signed [SW-1:0] base_s;
    logic signed [SW-1:0] sum;
    logic                 in_win;

    assign base_s = $signed({2'b00, addr_i});
    assign sum    = base_s + $signed({{2{step_i[ADDR_W-1]}}, step_i});
    assign in_win = (base_s >= LO_S) && (base_s < HI_S);

    always_comb begin
        addr_o = sum[ADDR_W-1:0];
        bank_o = bank_i;
        esc_o  = 1'b0;
        if (in_win) begin
            if (sum >= HI_S) begin
                addr_o = sum[ADDR_W-1:0] - WIN_SPAN;
                bank_o = bank_i + BANK_W'(1);
            end else if (sum < LO_S) begin
                addr_o = sum[ADDR_W-1:0] + WIN_SPAN;
                bank_o = bank_i - BANK_W'(1);
            end
        end else begin
            esc_o = (sum < 0) || (sum > TOP_S) || ((base_s < LO_S) && (sum >= LO_S));
        end
    end
endmodule

// File: rtl/sbdma_seq.sv
`timescale 1ns/1ps
module sbdma_seq import sbdma_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        finish_i,
    output xfer_state_e state_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= ST_IDLE;
        end else begin
            case (state_o)
                ST_IDLE:  if (start_i) state_o <= ST_READ;
                ST_READ:  state_o <= ST_WRITE;
                ST_WRITE: state_o <= finish_i ? ST_IDLE : ST_READ;
                default:  state_o <= ST_IDLE;
            endcase
        end
    end

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_READ) |=> (state_o == ST_WRITE)); // R3
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && !start_i) |=> (state_o == ST_IDLE)); // R9
endmodule

// File: rtl/strided_bank_dma.sv
`timescale 1ns/1ps
module strided_bank_dma import sbdma_pkg::*; #(
    parameter logic [ADDR_W-1:0] WIN_LO   = 16'hA000,
    parameter logic [ADDR_W-1:0] WIN_SPAN = 16'h2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANK_W-1:0] mem_bank,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int SIDES = 2;
    localparam int SRC   = 0;
    localparam int DST   = 1;
    localparam logic [ADDR_W:0] WIN_HI = {1'b0, WIN_LO} + {1'b0, WIN_SPAN};

    cursor_t           cur_q   [SIDES];
    cursor_t           start_q [SIDES];
    logic [ADDR_W-1:0] step_q  [SIDES];
    logic [ADDR_W-1:0] nxt_addr[SIDES];
    logic [BANK_W-1:0] nxt_bank[SIDES];
    logic              esc     [SIDES];

    logic [CNT_W-1:0]  cnt_q, cnt_start_q;
    logic [FLAG_W-1:0] reload_q;
    logic [DATA_W-1:0] hold_q;
    logic              halted_q;
    xfer_state_e       st;

    logic busy, go_acc, start, last, any_esc, finish;

    generate
        for (genvar g = 0; g < SIDES; g++) begin : g_side
            sbdma_ptr_step #(
                .ADDR_W  (ADDR_W),
                .BANK_W  (BANK_W),
                .WIN_LO  (WIN_LO),
                .WIN_SPAN(WIN_SPAN)
            ) u_step (
                .addr_i(cur_q[g].addr),
                .bank_i(cur_q[g].bank),
                .step_i(step_q[g]),
                .addr_o(nxt_addr[g]),
                .bank_o(nxt_bank[g]),
                .esc_o (esc[g])
            );
        end
    endgenerate

    assign busy    = (st != ST_IDLE);
    assign go_acc  = cfg_we && !busy && (cfg_sel == RA_CTRL);
    assign start   = go_acc && (cnt_q != '0);
    assign last    = (cnt_q == CNT_W'(1));
    assign any_esc = esc[SRC] || esc[DST];
    assign finish  = (st == ST_WRITE) && (last || any_esc);

    sbdma_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .finish_i(finish),
        .state_o (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < SIDES; g++) begin
                cur_q[g]   <= '0;
                start_q[g] <= '0;
                step_q[g]  <= '0;
            end
            cnt_q       <= '0;
            cnt_start_q <= '0;
            reload_q    <= '0;
            hold_q      <= '0;
            halted_q    <= 1'b0;
        end else begin
            if (cfg_we && !busy) begin
                case (cfg_sel)
                    RA_SRC_PTR:  cur_q[SRC].addr <= cfg_wdata;
                    RA_DST_PTR:  cur_q[DST].addr <= cfg_wdata;
                    RA_SRC_STEP: step_q[SRC]     <= cfg_wdata;
                    RA_DST_STEP: step_q[DST]     <= cfg_wdata;
                    RA_SRC_BANK: cur_q[SRC].bank <= cfg_wdata[BANK_W-1:0];
                    RA_DST_BANK: cur_q[DST].bank <= cfg_wdata[BANK_W-1:0];
                    RA_COUNT:    cnt_q           <= cfg_wdata;
                    default: begin
                        reload_q    <= cfg_wdata[FLAG_W-1:0];
                        cnt_start_q <= cnt_q;
                        halted_q    <= 1'b0;
                        for (int g = 0; g < SIDES; g++) start_q[g] <= cur_q[g];
                    end
                endcase
            end

            if (st == ST_READ) hold_q <= mem_rdata;

            if (st == ST_WRITE) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (last || !any_esc) begin
                    for (int g = 0; g < SIDES; g++) begin
                        cur_q[g].addr <= nxt_addr[g];
                        cur_q[g].bank <= nxt_bank[g];
                    end
                end else begin
                    halted_q <= 1'b1;
                end
                if (finish) begin
                    for (int g = 0; g < SIDES; g++) begin
                        if (reload_q[FL_PTR_BASE + g])  cur_q[g].addr <= start_q[g].addr;
                        if (reload_q[FL_BANK_BASE + g]) cur_q[g].bank <= start_q[g].bank;
                    end
                    if (reload_q[FL_COUNT]) cnt_q <= cnt_start_q;
                end
            end
        end
    end

    always_comb begin
        case (cfg_sel)
            RA_SRC_PTR:  cfg_rdata = cur_q[SRC].addr;
            RA_DST_PTR:  cfg_rdata = cur_q[DST].addr;
            RA_SRC_STEP: cfg_rdata = step_q[SRC];
            RA_DST_STEP: cfg_rdata = step_q[DST];
            RA_SRC_BANK: cfg_rdata = widen_bank(cur_q[SRC].bank);
            RA_DST_BANK: cfg_rdata = widen_bank(cur_q[DST].bank);
            RA_COUNT:    cfg_rdata = cnt_q;
            default:     cfg_rdata = {{(REG_W-2){1'b0}}, halted_q, busy};
        endcase
    end

    assign mem_req   = busy;
    assign mem_we    = (st == ST_WRITE);
    assign mem_addr  = mem_we ? cur_q[DST].addr : cur_q[SRC].addr;
    assign mem_bank  = mem_we ? cur_q[DST].bank : cur_q[SRC].bank;
    assign mem_wdata = hold_q;

    AST_READ_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we)); // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE && !finish) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R7
    AST_BUSY_IGNORES_CFG: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we) |=> ($stable(step_q[SRC]) && $stable(step_q[DST]))); // R10
    AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (go_acc && cnt_q == '0) |=> !mem_req); // R9
    AST_FIXED_DST: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE && !finish && step_q[DST] == '0) |=>
            ($stable(cur_q[DST].addr) && $stable(cur_q[DST].bank))); // R4
    AST_WINDOW_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE && !finish && cur_q[SRC].addr >= WIN_LO &&
         {1'b0, cur_q[SRC].addr} < WIN_HI) |=>
            (cur_q[SRC].addr >= WIN_LO && {1'b0, cur_q[SRC].addr} < WIN_HI)); // R5
    AST_HALT_LEAVES_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(halted_q) |-> (cnt_q != '0)); // R6
endmodule

// File: tb/strided_bank_dma_tb.sv
`timescale 1ns/1ps
module strided_bank_dma_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_bank, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    strided_bank_dma u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_bank(mem_bank),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  reported = 0;
    longint bus_cyc = 0;

    logic [7:0] mem  [0:4095];
    logic [7:0] emem [0:4095];

    function automatic logic [11:0] phys(input logic [15:0] a, input logic [7:0] b);
        logic w;
        w = (a >= 16'hA000) && (a < 16'hC000);
        return {w, w ? b[0] : 1'b0, a[9:0]};
    endfunction

    assign mem_rdata = mem[phys(mem_addr, mem_bank)];
    always @(posedge clk) begin
        if (mem_req) bus_cyc++;
        if (mem_req && mem_we) mem[phys(mem_addr, mem_bank)] = mem_wdata;
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void bstep(input logic [15:0] a, input logic [7:0] b, input logic [15:0] st,
                                  output logic [15:0] na, output logic [7:0] nb, output bit e);
        int sum;
        sum = int'(a) + int'($signed(st));
        nb = b;
        e  = 0;
        if (a >= 16'hA000 && a < 16'hC000) begin
            if (sum >= 49152) begin sum -= 8192; nb = b + 8'd1; end
            else if (sum < 40960) begin sum += 8192; nb = b - 8'd1; end
        end else begin
            e = (sum < 0) || (sum > 65535) || (a < 16'hA000 && sum >= 40960);
        end
        na = sum[15:0];
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        cfg_sel = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic run(input logic [15:0] s, input logic [15:0] d, input logic [15:0] ss,
                       input logic [15:0] ds, input logic [7:0] sb, input logic [7:0] db,
                       input logic [15:0] cnt, input logic [4:0] fl, input bit poke, input string tag);
        logic [15:0] ms, md, ns, nd, v, ecnt;
        logic [7:0]  msb, mdb, nsb, ndb;
        bit es, ed, hlt;
        int moved;
        longint b0;
        int bad;
        wr(3'd0, s); wr(3'd1, d); wr(3'd2, ss); wr(3'd3, ds);
        wr(3'd4, {8'd0, sb}); wr(3'd5, {8'd0, db}); wr(3'd6, cnt);
        ms = s; md = d; msb = sb; mdb = db; moved = 0; hlt = 0;
        for (int i = 0; i < int'(cnt); i++) begin
            emem[phys(md, mdb)] = emem[phys(ms, msb)];
            moved++;
            bstep(ms, msb, ss, ns, nsb, es);
            bstep(md, mdb, ds, nd, ndb, ed);
            if (i != int'(cnt) - 1 && (es || ed)) begin hlt = 1; break; end
            ms = ns; md = nd; msb = nsb; mdb = ndb;
        end
        ecnt = cnt - 16'(moved);
        if (fl[0]) ms = s;
        if (fl[1]) md = d;
        if (fl[2]) msb = sb;
        if (fl[3]) mdb = db;
        if (fl[4]) ecnt = cnt;
        b0 = bus_cyc;
        wr(3'd7, {11'd0, fl});
        rd(3'd7, v);
        check("R11", "busy after launch", v[0], (cnt != 0));
        if (poke) begin
            wr(3'd2, 16'h0007);
            wr(3'd0, 16'h1234);
            wr(3'd7, 16'h001F);
        end
        do begin
            @(negedge clk);
            rd(3'd7, v);
        end while (v[0]);
        check("R11", "status busy/halted", v[1:0], {hlt, 1'b0});
        if (hlt) check("R6", "halted flag", v[1], 1);
        check("R3", "bus clocks", bus_cyc - b0, 2 * moved);
        rd(3'd0, v); check(tag, "src addr", v, ms);
        rd(3'd1, v); check(tag, "dst addr", v, md);
        rd(3'd4, v); check(tag, "src bank", v, {8'd0, msb});
        rd(3'd5, v); check(tag, "dst bank", v, {8'd0, mdb});
        rd(3'd6, v); check(tag, "count", v, ecnt);
        rd(3'd2, v); check(poke ? "R10" : "R2", "src step", v, ss);
        rd(3'd3, v); check("R2", "dst step", v, ds);
        bad = 0;
        for (int k = 0; k < 4096; k++) if (mem[k] !== emem[k]) bad++;
        check("R3", "memory mismatches", bad, 0);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        for (int k = 0; k < 4096; k++) begin
            mem[k]  = 8'($urandom);
            emem[k] = mem[k];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1", "reset register", v, 0);
        end
        check("R1", "mem_req after reset", mem_req, 0);

        run(16'h0100, 16'h0400, 16'd1, 16'd1, 8'd0, 8'd0, 16'd16, 5'h00, 0, "R7");
        run(16'h0200, 16'hBFFC, 16'd1, 16'd1, 8'd0, 8'd2, 16'd8, 5'h00, 0, "R5");
        run(16'hA002, 16'h0300, 16'hFFFF, 16'd2, 8'd1, 8'd0, 16'd6, 5'h00, 0, "R5");
        run(16'h0500, 16'h9F23, 16'd1, 16'd0, 8'd0, 8'd0, 16'd5, 5'h00, 0, "R4");
        run(16'h0003, 16'h0600, 16'hFFFF, 16'd1, 8'd0, 8'd0, 16'd10, 5'h00, 0, "R6");
        run(16'h0700, 16'h0800, 16'd1, 16'd1, 8'd0, 8'd0, 16'd0, 5'h1F, 0, "R9");
        run(16'h0010, 16'h9FFD, 16'd1, 16'd1, 8'd0, 8'd0, 16'd10, 5'h00, 0, "R6");
        run(16'h0020, 16'h9FFF, 16'd1, 16'd1, 8'd0, 8'd0, 16'd1, 5'h00, 0, "R6");
        run(16'h0003, 16'h0600, 16'hFFFF, 16'd1, 8'd0, 8'd0, 16'd10, 5'h1F, 0, "R8");
        run(16'h0100, 16'hA000, 16'd2, 16'd1, 8'd3, 8'd4, 16'd12, 5'h15, 0, "R8");
        run(16'h0900, 16'h0A00, 16'd1, 16'd1, 8'd0, 8'd0, 16'd20, 5'h00, 1, "R10");

        for (int t = 0; t < 30; t++) begin
            logic [15:0] rs, rdd;
            rs  = $urandom_range(0, 1) ? 16'(16'hA000 + $urandom_range(0, 8191)) : 16'($urandom_range(0, 16'h9FFF));
            rdd = $urandom_range(0, 1) ? 16'(16'hA000 + $urandom_range(0, 8191)) : 16'($urandom_range(0, 16'h9FFF));
            run(rs, rdd, 16'($signed($urandom_range(0, 8)) - 4), 16'($signed($urandom_range(0, 8)) - 4),
                8'($urandom), 8'($urandom), 16'($urandom_range(1, 40)), 5'($urandom), 0, "R7");
        end
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule